// File: doc/BRIEF.md
# Status LED Restart Indicator

This block drives one board status pin that serves two purposes. While the processor power-on reset line is held low, the pin shows a slow square-wave blink. This marks that a watchdog restart is in progress. The blink also continues for a fixed hold window after the reset line goes high. Only when that window has run out does the pin start to follow a user status line coming from the FPGA fabric. It keeps following that line until the reset line drops again.

Both the reset line and the user line come from other clock domains. Each passes through a two-flop synchronizer before any logic uses it. The blink half-period is derived from a clock-frequency parameter, which gives roughly a 1 s period at 50% duty. The hold window is a whole number of seconds set by its own parameter, so a bench can shrink it. The block uses a synchronous active-high reset.

Top module: `statled_top`

## Requirements
- R1: While `rst` is high at a clock edge, `stat_o` is low after that edge, the blink phase is low, and the block is in blink mode with the hold count cleared.
- R2: In blink mode, `stat_o` shows a square wave whose half-period is HALF = CLK_HZ/2 cycles. Counting the first edge with `rst` low as edge 1, the output after edge n equals bit 0 of floor((n-1)/HALF), so it starts low.
- R3: In blink mode, the value of `user_raw` has no effect on `stat_o`.
- R4: Let edge k be the first edge of a run of edges at which `por_raw` is sampled high. The output keeps blinking through edge k+2+HOLD, where HOLD = HOLD_SEC*CLK_HZ. It shows the user value from edge k+3+HOLD on.
- R5: In user mode, `stat_o` after edge e equals `user_raw` as sampled at edge e-2, which is the two-flop synchronizer latency plus the output register.
- R6: A low level on `por_raw`, even one sampled at a single edge, returns the block to blink mode and clears the hold count. If that low is sampled at edge j, the output is the blink phase from edge j+3 on, and a complete new hold window is needed before user mode returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, frequency CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| por_raw | input | 1 | Asynchronous active-low processor power-on reset |
| user_raw | input | 1 | Asynchronous user status line from the FPGA |
| stat_o | output | 1 | Status pin: blink pattern or user value |

## Verification
The bench drives random user data while the reset line is low. This shows that the blink phase ignores the user line. It then releases the reset line and lets the full hold window run. The cycle of handover is compared exactly, so a window that is one cycle short or long is caught. The reset line is also dropped for a single cycle, both inside the hold window and inside user mode. These cases tell a hold counter that restarts apart from one that merely pauses, and show whether the exit back to blink has the right latency. Random stretches of reset activity, some long and some short, mix all of these transitions.

// File: rtl/statled_pkg.sv
package statled_pkg;

    typedef enum logic [1:0] {
        MODE_PORBLINK  = 2'd0,
        MODE_HOLDBLINK = 2'd1,
        MODE_USER      = 2'd2
    } led_mode_e;

    typedef struct packed {
        logic por_n;
        logic user;
    } led_in_t;

    localparam int unsigned IN_W = $bits(led_in_t);

    function automatic int unsigned cnt_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/statled_sync.sv
module statled_sync #(
    parameter int unsigned W      = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], d[b]};
        end
        assign q[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/statled_blink.sv
module statled_blink #(
    parameter int unsigned HALF = 8
) (
    input  logic clk,
    input  logic rst,
    output logic phase
);
    localparam int unsigned CW = statled_pkg::cnt_w(HALF);
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (cnt == LAST) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/statled_mode.sv
module statled_mode
    import statled_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 64,
    localparam int unsigned CW = cnt_w(HOLD_CYCLES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          por_s,
    output led_mode_e     mode,
    output logic [CW-1:0] hold_cnt
);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    always_ff @(posedge clk) begin
        if (rst || !por_s) begin
            mode     <= MODE_PORBLINK;
            hold_cnt <= '0;
        end else begin
            unique case (mode)
                MODE_PORBLINK: begin
                    mode     <= MODE_HOLDBLINK;
                    hold_cnt <= '0;
                end
                MODE_HOLDBLINK: begin
                    if (hold_cnt == LAST) mode <= MODE_USER;
                    else                  hold_cnt <= hold_cnt + 1'b1;
                end
                default: mode <= MODE_USER;
            endcase
        end
    end
endmodule

// File: rtl/statled_top.sv
module statled_top
    import statled_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 100_000_000,
    parameter int unsigned HOLD_SEC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic por_raw,
    input  logic user_raw,
    output logic stat_o
);
    localparam int unsigned HALF        = (CLK_HZ / 2 < 1) ? 1 : CLK_HZ / 2;
    localparam int unsigned HOLD_CYCLES = (HOLD_SEC * CLK_HZ < 1) ? 1 : HOLD_SEC * CLK_HZ;
    localparam int unsigned CW          = cnt_w(HOLD_CYCLES);

    led_in_t       raw_in, sync_in;
    logic          por_s, user_s, phase;
    led_mode_e     mode;
    logic [CW-1:0] hold_cnt;

    assign raw_in.por_n = por_raw;
    assign raw_in.user  = user_raw;

    statled_sync #(.W(IN_W), .STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .d(raw_in), .q(sync_in)
    );

    assign por_s  = sync_in.por_n;
    assign user_s = sync_in.user;

    statled_blink #(.HALF(HALF)) u_blink (
        .clk(clk), .rst(rst), .phase(phase)
    );

    statled_mode #(.HOLD_CYCLES(HOLD_CYCLES)) u_mode (
        .clk(clk), .rst(rst), .por_s(por_s), .mode(mode), .hold_cnt(hold_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) stat_o <= 1'b0;
        else     stat_o <= (mode == MODE_USER) ? user_s : phase;
    end
endmodule

// File: rtl/statled_checker.sv
module statled_checker
    import statled_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 64,
    localparam int unsigned CW = cnt_w(HOLD_CYCLES)
) (
    input logic          clk,
    input logic          rst,
    input logic          por_s,
    input logic          user_s,
    input logic          phase,
    input led_mode_e     mode,
    input logic [CW-1:0] hold_cnt,
    input logic          stat_o
);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    assert_user_follow_R5: assert property (@(posedge clk) disable iff (rst)
        $past(mode == MODE_USER) |-> stat_o == $past(user_s));

    assert_blink_phase_R2: assert property (@(posedge clk) disable iff (rst)
        $past(mode != MODE_USER) |-> stat_o == $past(phase));

    assert_no_skip_R4: assert property (@(posedge clk) disable iff (rst)
        $past(mode == MODE_PORBLINK) |-> mode != MODE_USER);

    assert_full_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_USER && $past(mode == MODE_HOLDBLINK)) |-> $past(hold_cnt) == LAST);

    assert_hold_range_R4: assert property (@(posedge clk) disable iff (rst)
        hold_cnt <= LAST);

    assert_por_restart_R6: assert property (@(posedge clk) disable iff (rst)
        !por_s |=> (mode == MODE_PORBLINK && hold_cnt == '0));
endmodule

bind statled_top statled_checker #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
    .clk(clk), .rst(rst), .por_s(por_s), .user_s(user_s), .phase(phase),
    .mode(mode), .hold_cnt(hold_cnt), .stat_o(stat_o)
);

// File: tb/test_statled_top.sv
`timescale 1ns/1ps
module test_statled_top;
    localparam int CLK_HZ   = 16;
    localparam int HOLD_SEC = 4;
    localparam int HALF     = CLK_HZ / 2;
    localparam int HOLD     = HOLD_SEC * CLK_HZ;
    localparam int LIMIT    = 100000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic por_raw = 1'b0;
    logic user_raw = 1'b0;
    logic stat_o;

    always #2 clk = ~clk;

    statled_top #(.CLK_HZ(CLK_HZ), .HOLD_SEC(HOLD_SEC)) i_statled_top (
        .clk(clk), .rst(rst), .por_raw(por_raw), .user_raw(user_raw), .stat_o(stat_o)
    );

    int   n_cmp = 0, n_bad = 0, cycles = 0;
    bit   done = 1'b0;
    logic [2:0] uh = '0;     // uh[i]: user_raw sampled i edges ago
    int   pch [0:3];         // pch[i]: high-run length of por_raw after edge e-i
    int   tc = 0;            // edges with rst low
    bit   rst_q = 1'b1;
    int   since_user = 99;

    initial for (int i = 0; i < 4; i++) pch[i] = 0;

    always @(posedge clk) begin
        int npc;
        cycles <= cycles + 1;
        rst_q  <= rst;
        uh     <= {uh[1:0], user_raw};
        npc = (rst || !por_raw) ? 0 : pch[0] + 1;
        pch[3] <= pch[2]; pch[2] <= pch[1]; pch[1] <= pch[0]; pch[0] <= npc;
        tc <= rst ? 0 : tc + 1;
    end

    function automatic logic exp_blink(input int t);
        return ((t - 1) / HALF) % 2 == 1;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: stat_o=%b expected %b at cycle %0d", req, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        if (!done && cycles > 0) begin
            if (rst_q) begin
                chk("R1", stat_o, 1'b0);
            end else if (pch[3] >= HOLD + 1) begin
                chk((pch[3] == HOLD + 1) ? "R4" : "R5", stat_o, uh[2]);
                since_user = 0;
            end else begin
                if (since_user < 3)  chk("R6", stat_o, exp_blink(tc));
                else if (pch[3] > 0) chk("R4", stat_o, exp_blink(tc));
                else                 chk("R2 R3", stat_o, exp_blink(tc));
                if (since_user < 99) since_user++;
            end
        end
    end

    task automatic drive(input logic p, input int n, input bit rnd_user);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            por_raw = p;
            if (rnd_user) user_raw = $urandom_range(0, 1);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > LIMIT && !done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < %0d", cycles, LIMIT);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        drive(1'b0, 5, 1'b1);           // R1: reset with random user
        @(negedge clk); rst = 1'b0;
        drive(1'b0, 40, 1'b1);          // R2 R3: blink while por low
        drive(1'b1, HOLD + 30, 1'b1);   // R4 R5: hold then handover
        drive(1'b0, 1, 1'b1);           // R6: single-cycle low in user mode
        drive(1'b1, HOLD / 2, 1'b1);    // hold partially elapsed
        drive(1'b0, 1, 1'b1);           // R6: restart mid-hold
        drive(1'b1, HOLD + 20, 1'b1);
        user_raw = 1'b1;
        drive(1'b1, 6, 1'b0);           // R5: constant high user
        user_raw = 1'b0;
        drive(1'b1, 6, 1'b0);           // R5: constant low user
        for (int k = 0; k < 30; k++) begin
            drive(1'b0, $urandom_range(1, 12), 1'b1);
            drive(1'b1, ($urandom_range(0, 2) == 0) ? $urandom_range(1, 20)
                                                   : HOLD + $urandom_range(0, 40), 1'b1);
        end
        @(negedge clk); rst = 1'b1;     // R1: reset again from user mode
        drive(por_raw, 4, 1'b1);
        finish_run();
    end
endmodule